// File: doc/BRIEF.md
# Instruction Exception Classifier and Synchronizer

This block sits beside the dispatch stage of an in-order pipeline. Each cycle it can receive one decoded instruction as a set of class flags, together with the machine-state bits that govern it: user mode, floating point available, and floating-point exceptions enabled. It also receives the alignment and page-fault results from address generation and a count of older instructions still in flight. From these inputs it decides whether the instruction causes an exception and, if it does, which handler cause applies. The cause is reported one cycle later as a single-cycle strobe with a 4-bit cause code.

System call and return-from-interrupt are context-synchronizing. If older instructions are still in flight when either one is accepted, the block raises a stall that holds dispatch. The held instruction is released once the in-flight count reaches zero. A system call then raises its exception. A return-from-interrupt releases silently. While an instruction is held, new dispatch attempts are ignored.

Top module: `insn_fault_sorter`

## Requirements
- R1: An instruction flagged illegal raises cause code 1. It wins over every other cause.
- R2: In user mode, cause code 2 is raised by any of these: an instruction of the supervisor-only group, a return-from-interrupt, or a special-register move whose register number is flagged privileged. The same instructions in supervisor mode, and a special-register move to an unprivileged number, raise no exception.
- R3: A floating-point instruction issued while floating point is unavailable raises cause code 3.
- R4: A page fault raises cause code 4. An alignment fault raises cause code 5. When both are present, the page fault wins.
- R5: A trap instruction whose condition is met raises cause code 6. A trap whose condition is not met raises nothing.
- R6: A floating-point instruction with floating point available, exceptions enabled and an exception produced raises cause code 7. With exceptions disabled it raises nothing.
- R7: Simultaneous causes resolve in this fixed order, highest first: 1, 2, 3, 4, 5, then 6 before 7, then 8.
- R8: A system call accepted with an in-flight count of zero raises cause code 8 in the next cycle.
- R9: A system call or return-from-interrupt accepted with a nonzero in-flight count asserts the stall output in the same cycle. The stall stays high up to and including the cycle in which the count reads zero. A held system call raises cause code 8 in the cycle after that. A held return-from-interrupt releases with no exception.
- R10: While an instruction is held, dispatch attempts are ignored, including an attempt in the release cycle. This is true even when the ignored instruction would fault.
- R11: The strobe is registered. It appears exactly one cycle after the accepted instruction and lasts one cycle per exception. After reset the strobe and the stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid_i | input | 1 | A decoded instruction is presented this cycle |
| illegal_i | input | 1 | Instruction is illegal |
| super_only_i | input | 1 | Instruction belongs to the supervisor-only group |
| spr_move_i | input | 1 | Move to or from a special-purpose register |
| spr_priv_i | input | 1 | The addressed special-register number is privileged |
| trap_i | input | 1 | Instruction is a conditional trap |
| trap_hit_i | input | 1 | The trap condition is met |
| fp_op_i | input | 1 | Instruction is a floating-point operation |
| fp_raise_i | input | 1 | The floating-point operation produces an exception |
| syscall_i | input | 1 | Instruction is a system call |
| retint_i | input | 1 | Instruction is a return-from-interrupt |
| user_mode_i | input | 1 | Machine is in user mode |
| fp_avail_i | input | 1 | Floating point is available |
| fp_exc_en_i | input | 1 | Floating-point exceptions are enabled |
| align_fault_i | input | 1 | Address generation reports an invalid alignment |
| page_fault_i | input | 1 | The access targets unavailable memory |
| inflight_i | input | INFLIGHT_W | Number of older instructions not yet completed |
| exc_valid_o | output | 1 | Single-cycle exception strobe |
| exc_cause_o | output | 4 | Cause code for the strobe |
| stall_o | output | 1 | Holds dispatch while a synchronizing instruction drains |

## Verification
Two events can fall in the same cycle. One is the release of a held system call, when the in-flight count reaches zero. The other is a new dispatch attempt carrying its own fault, for example an illegal instruction. The bench holds a system call behind a nonzero count and keeps presenting a faulting instruction while the count steps down to zero. The result is judged correct only if exactly one strobe follows, carrying cause 8, with no strobe for the dropped instruction. A second collision sets several cause flags on one instruction to check the resolution order.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
   localparam int unsigned N_CAUSE = 8;

   typedef enum logic [3:0] {
      CS_NONE    = 4'd0,
      CS_ILLEGAL = 4'd1,
      CS_PRIV    = 4'd2,
      CS_FP_OFF  = 4'd3,
      CS_PAGE    = 4'd4,
      CS_ALIGN   = 4'd5,
      CS_TRAP    = 4'd6,
      CS_FP_PROG = 4'd7,
      CS_SYSCALL = 4'd8
   } cause_e;

   // maps a priority rank (0 = highest) to its cause code
   function automatic cause_e rank_code(input int unsigned rank, input bit trap_first);
      case (rank)
         0: return CS_ILLEGAL;
         1: return CS_PRIV;
         2: return CS_FP_OFF;
         3: return CS_PAGE;
         4: return CS_ALIGN;
         5: return trap_first ? CS_TRAP : CS_FP_PROG;
         6: return trap_first ? CS_FP_PROG : CS_TRAP;
         7: return CS_SYSCALL;
         default: return CS_NONE;
      endcase
   endfunction
endpackage

// File: rtl/ifs_cause_eval.sv
module ifs_cause_eval
   import ifs_pkg::*;
#(
   parameter bit TRAP_FIRST = 1'b1
) (
   input  logic               illegal_i,
   input  logic               super_only_i,
   input  logic               spr_move_i,
   input  logic               spr_priv_i,
   input  logic               trap_i,
   input  logic               trap_hit_i,
   input  logic               fp_op_i,
   input  logic               fp_raise_i,
   input  logic               syscall_i,
   input  logic               retint_i,
   input  logic               user_mode_i,
   input  logic               fp_avail_i,
   input  logic               fp_exc_en_i,
   input  logic               align_fault_i,
   input  logic               page_fault_i,
   output logic [N_CAUSE-1:0] req_o
);
   logic priv_hit;
   logic fp_off_hit;
   logic fp_prog_hit;
   logic trap_taken;

   assign priv_hit    = user_mode_i & (super_only_i | retint_i | (spr_move_i & spr_priv_i));
   assign fp_off_hit  = fp_op_i & ~fp_avail_i;
   assign fp_prog_hit = fp_op_i & fp_avail_i & fp_exc_en_i & fp_raise_i;
   assign trap_taken  = trap_i & trap_hit_i;

   assign req_o[0] = illegal_i;
   assign req_o[1] = priv_hit;
   assign req_o[2] = fp_off_hit;
   assign req_o[3] = page_fault_i;
   assign req_o[4] = align_fault_i;
   assign req_o[7] = syscall_i;

   if (TRAP_FIRST) begin : g_trap_hi
      assign req_o[5] = trap_taken;
      assign req_o[6] = fp_prog_hit;
   end else begin : g_fpp_hi
      assign req_o[5] = fp_prog_hit;
      assign req_o[6] = trap_taken;
   end
endmodule

// File: rtl/ifs_rank_pick.sv
module ifs_rank_pick #(
   parameter int unsigned N = 8,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   logic [N:0]   seen;
   logic [N-1:0] gnt;

   if (N < 2) begin : g_bad_n
      $error("ifs_rank_pick: N must be at least 2");
   end

   assign seen[0] = 1'b0;
   for (genvar g = 0; g < N; g++) begin : g_chain
      assign gnt[g]    = req_i[g] & ~seen[g];
      assign seen[g+1] = seen[g] | req_i[g];
   end

   assign any_o = seen[N];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (gnt[i]) idx_o = idx_o | IW'(i);
      end
   end
endmodule

// File: rtl/ifs_sync_ctl.sv
module ifs_sync_ctl #(
   parameter int unsigned INFLIGHT_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sync_req_i,
   input  logic                  sync_sc_i,
   input  logic [INFLIGHT_W-1:0] inflight_i,
   output logic                  waiting_o,
   output logic                  release_sc_o,
   output logic                  stall_o
);
   logic drained;
   logic wait_q, wait_d;
   logic kind_q, kind_d;

   assign drained = (inflight_i == '0);

   always_comb begin
      wait_d       = wait_q;
      kind_d       = kind_q;
      release_sc_o = 1'b0;
      if (wait_q) begin
         if (drained) begin
            wait_d       = 1'b0;
            release_sc_o = kind_q;
         end
      end else if (sync_req_i && !drained) begin
         wait_d = 1'b1;
         kind_d = sync_sc_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_q <= 1'b0;
         kind_q <= 1'b0;
      end else begin
         wait_q <= wait_d;
         kind_q <= kind_d;
      end
   end

   assign waiting_o = wait_q;
   assign stall_o   = wait_q | (sync_req_i & ~drained);
endmodule

// File: rtl/insn_fault_sorter.sv
module insn_fault_sorter
   import ifs_pkg::*;
#(
   parameter int unsigned INFLIGHT_W = 4,
   parameter bit          TRAP_FIRST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  issue_valid_i,
   input  logic                  illegal_i,
   input  logic                  super_only_i,
   input  logic                  spr_move_i,
   input  logic                  spr_priv_i,
   input  logic                  trap_i,
   input  logic                  trap_hit_i,
   input  logic                  fp_op_i,
   input  logic                  fp_raise_i,
   input  logic                  syscall_i,
   input  logic                  retint_i,
   input  logic                  user_mode_i,
   input  logic                  fp_avail_i,
   input  logic                  fp_exc_en_i,
   input  logic                  align_fault_i,
   input  logic                  page_fault_i,
   input  logic [INFLIGHT_W-1:0] inflight_i,
   output logic                  exc_valid_o,
   output logic [3:0]            exc_cause_o,
   output logic                  stall_o
);
   localparam int unsigned IDX_W   = $clog2(N_CAUSE);
   localparam int unsigned SC_RANK = N_CAUSE - 1;

   if (INFLIGHT_W < 1) begin : g_bad_w
      $error("insn_fault_sorter: INFLIGHT_W must be at least 1");
   end

   logic [N_CAUSE-1:0] req;
   logic               any_req;
   logic [IDX_W-1:0]   win;
   logic               waiting;
   logic               accept;
   logic               is_sc;
   logic               sync_req;
   logic               release_sc;
   logic               fire_d;
   cause_e             cause_d;
   logic               exc_valid_q;
   cause_e             exc_cause_q;

   ifs_cause_eval #(.TRAP_FIRST(TRAP_FIRST)) u_eval (
      .illegal_i    (illegal_i),
      .super_only_i (super_only_i),
      .spr_move_i   (spr_move_i),
      .spr_priv_i   (spr_priv_i),
      .trap_i       (trap_i),
      .trap_hit_i   (trap_hit_i),
      .fp_op_i      (fp_op_i),
      .fp_raise_i   (fp_raise_i),
      .syscall_i    (syscall_i),
      .retint_i     (retint_i),
      .user_mode_i  (user_mode_i),
      .fp_avail_i   (fp_avail_i),
      .fp_exc_en_i  (fp_exc_en_i),
      .align_fault_i(align_fault_i),
      .page_fault_i (page_fault_i),
      .req_o        (req)
   );

   ifs_rank_pick #(.N(N_CAUSE)) u_pick (
      .req_i(req),
      .any_o(any_req),
      .idx_o(win)
   );

   assign accept   = issue_valid_i & ~waiting;
   assign is_sc    = any_req & (win == IDX_W'(SC_RANK));
   assign sync_req = accept & (is_sc | (~any_req & retint_i));

   ifs_sync_ctl #(.INFLIGHT_W(INFLIGHT_W)) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_req_i  (sync_req),
      .sync_sc_i   (is_sc),
      .inflight_i  (inflight_i),
      .waiting_o   (waiting),
      .release_sc_o(release_sc),
      .stall_o     (stall_o)
   );

   always_comb begin
      fire_d  = 1'b0;
      cause_d = CS_NONE;
      if (release_sc) begin
         fire_d  = 1'b1;
         cause_d = CS_SYSCALL;
      end else if (accept && any_req && !(is_sc && inflight_i != '0)) begin
         fire_d  = 1'b1;
         cause_d = rank_code(int'(win), TRAP_FIRST);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exc_valid_q <= 1'b0;
         exc_cause_q <= CS_NONE;
      end else begin
         exc_valid_q <= fire_d;
         exc_cause_q <= cause_d;
      end
   end

   assign exc_valid_o = exc_valid_q;
   assign exc_cause_o = exc_cause_q;
endmodule

// File: rtl/ifs_checker.sv
module ifs_checker #(
   parameter int unsigned INFLIGHT_W = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  issue_valid_i,
   input logic                  illegal_i,
   input logic                  user_mode_i,
   input logic                  fp_avail_i,
   input logic [INFLIGHT_W-1:0] inflight_i,
   input logic                  exc_valid_o,
   input logic [3:0]            exc_cause_o,
   input logic                  stall_o
);
   AST_ILLEGAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_i && illegal_i && !stall_o |=> exc_valid_o && exc_cause_o == 4'd1); // R1

   AST_PRIV_NEEDS_USER: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_i && !user_mode_i && !stall_o |=> !(exc_valid_o && exc_cause_o == 4'd2)); // R2

   AST_FPOFF_NEEDS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_i && fp_avail_i && !stall_o |=> !(exc_valid_o && exc_cause_o == 4'd3)); // R3

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o && inflight_i != '0 |=> stall_o); // R9

   AST_NO_EXC_WHILE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o && inflight_i != '0 |=> !exc_valid_o); // R10

   AST_CAUSE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid_o |-> exc_cause_o != 4'd0 && exc_cause_o <= 4'd8); // R11
endmodule

bind insn_fault_sorter ifs_checker #(.INFLIGHT_W(INFLIGHT_W)) u_chk (.*);

// File: tb/tb_insn_fault_sorter.sv
module tb_insn_fault_sorter;
   localparam int unsigned IW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic issue_valid_i, illegal_i, super_only_i, spr_move_i, spr_priv_i;
   logic trap_i, trap_hit_i, fp_op_i, fp_raise_i, syscall_i, retint_i;
   logic user_mode_i, fp_avail_i, fp_exc_en_i, align_fault_i, page_fault_i;
   logic [IW-1:0] inflight_i;
   logic exc_valid_o;
   logic [3:0] exc_cause_o;
   logic stall_o;

   always #10 clk = ~clk;

   insn_fault_sorter #(.INFLIGHT_W(IW), .TRAP_FIRST(1'b1)) dut (.*);

   typedef struct packed {
      logic vld, ill, sup, spr, sprp, tw, th, fp, fpx, sc, rfi, usr, fpa, fpe, al, pf;
   } stim_t;

   typedef struct {
      logic       v;
      logic [3:0] c;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   logic m_wait = 1'b0;
   logic m_kind = 1'b0;
   bit   done = 1'b0;

   function automatic stim_t idle();
      stim_t s = '0;
      s.vld = 1'b1;
      s.fpa = 1'b1;
      return s;
   endfunction

   function automatic logic [3:0] want_cause(stim_t s);
      if (s.ill) return 4'd1;
      if (s.usr && (s.sup || s.rfi || (s.spr && s.sprp))) return 4'd2;
      if (s.fp && !s.fpa) return 4'd3;
      if (s.pf) return 4'd4;
      if (s.al) return 4'd5;
      if (s.tw && s.th) return 4'd6;
      if (s.fp && s.fpa && s.fpe && s.fpx) return 4'd7;
      if (s.sc) return 4'd8;
      return 4'd0;
   endfunction

   task automatic cyc(input stim_t s, input int infl, input string tag);
      exp_t e;
      logic exp_stall;
      logic [3:0] c;
      @(negedge clk);
      issue_valid_i = s.vld;  illegal_i = s.ill;  super_only_i = s.sup;
      spr_move_i = s.spr;     spr_priv_i = s.sprp; trap_i = s.tw;
      trap_hit_i = s.th;      fp_op_i = s.fp;     fp_raise_i = s.fpx;
      syscall_i = s.sc;       retint_i = s.rfi;   user_mode_i = s.usr;
      fp_avail_i = s.fpa;     fp_exc_en_i = s.fpe; align_fault_i = s.al;
      page_fault_i = s.pf;    inflight_i = IW'(infl);
      e.v = 1'b0; e.c = 4'd0; e.tag = tag;
      exp_stall = 1'b0;
      if (m_wait) begin
         exp_stall = 1'b1;
         if (infl == 0) begin
            m_wait = 1'b0;
            if (m_kind) begin e.v = 1'b1; e.c = 4'd8; end
         end
      end else if (s.vld) begin
         c = want_cause(s);
         if ((c == 4'd8 || (c == 4'd0 && s.rfi)) && infl != 0) begin
            exp_stall = 1'b1;
            m_wait = 1'b1;
            m_kind = (c == 4'd8);
         end else if (c != 4'd0) begin
            e.v = 1'b1; e.c = c;
         end
      end
      #1;
      n_vec++;
      if (stall_o !== exp_stall) begin
         n_bad++;
         $display("FAIL %s stall: actual %b expected %b", tag, stall_o, exp_stall);
      end
      exp_q.push_back(e);
   endtask

   // monitor: compares the registered strobe one edge after each driven cycle
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_vec++;
            if (exc_valid_o !== e.v || (e.v && exc_cause_o !== e.c)) begin
               n_bad++;
               $display("FAIL %s strobe: actual %b/%0d expected %b/%0d",
                        e.tag, exc_valid_o, exc_cause_o, e.v, e.c);
            end
         end
      end
   end

   task automatic wrap_up();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         wrap_up();
      end
   end

   initial begin
      stim_t s;
      s = idle();
      s.vld = 1'b0;
      issue_valid_i = 0; illegal_i = 0; super_only_i = 0; spr_move_i = 0;
      spr_priv_i = 0; trap_i = 0; trap_hit_i = 0; fp_op_i = 0; fp_raise_i = 0;
      syscall_i = 0; retint_i = 0; user_mode_i = 0; fp_avail_i = 1;
      fp_exc_en_i = 0; align_fault_i = 0; page_fault_i = 0; inflight_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      n_vec++;
      if (exc_valid_o !== 1'b0 || stall_o !== 1'b0) begin
         n_bad++;
         $display("FAIL R11 reset: actual %b%b expected 00", exc_valid_o, stall_o);
      end

      // R1: illegal alone and with every other flag
      s = idle(); s.ill = 1;                                   cyc(s, 0, "R1");
      s = idle(); s.ill = 1; s.usr = 1; s.sup = 1; s.pf = 1; s.sc = 1; cyc(s, 5, "R1 R7");
      // R2: privileged group, return-from-interrupt, special-register moves
      s = idle(); s.usr = 1; s.sup = 1;                        cyc(s, 0, "R2 sup");
      s = idle(); s.usr = 1; s.rfi = 1;                        cyc(s, 3, "R2 rfi");
      s = idle(); s.usr = 1; s.spr = 1; s.sprp = 1;            cyc(s, 0, "R2 sprp");
      s = idle(); s.usr = 1; s.spr = 1;                        cyc(s, 0, "R2 spr open");
      s = idle(); s.sup = 1; s.spr = 1; s.sprp = 1;            cyc(s, 0, "R2 supervisor");
      // R3 / R6
      s = idle(); s.fp = 1; s.fpa = 0; s.fpx = 1; s.fpe = 1;   cyc(s, 0, "R3");
      s = idle(); s.fp = 1; s.fpe = 1; s.fpx = 1;              cyc(s, 0, "R6");
      s = idle(); s.fp = 1; s.fpx = 1;                         cyc(s, 0, "R6 masked");
      // R4
      s = idle(); s.pf = 1;                                    cyc(s, 0, "R4 page");
      s = idle(); s.al = 1;                                    cyc(s, 0, "R4 align");
      s = idle(); s.al = 1; s.pf = 1;                          cyc(s, 0, "R4 both");
      // R5
      s = idle(); s.tw = 1; s.th = 1;                          cyc(s, 0, "R5 taken");
      s = idle(); s.tw = 1;                                    cyc(s, 0, "R5 untaken");
      // R7 collisions
      s = idle(); s.tw = 1; s.th = 1; s.fp = 1; s.fpe = 1; s.fpx = 1; cyc(s, 0, "R7 trap-fpp");
      s = idle(); s.fp = 1; s.fpa = 0; s.pf = 1; s.al = 1;     cyc(s, 0, "R7 fpoff-page");
      s = idle(); s.al = 1; s.sc = 1;                          cyc(s, 4, "R7 align-sc");
      // R8
      s = idle(); s.sc = 1;                                    cyc(s, 0, "R8");
      // R9 / R10: held system call with colliding dispatch
      s = idle(); s.sc = 1;                                    cyc(s, 2, "R9 hold");
      s = idle(); s.ill = 1;                                   cyc(s, 1, "R10 drain");
      s = idle(); s.ill = 1;                                   cyc(s, 0, "R10 release");
      s = idle(); s.vld = 0;                                   cyc(s, 0, "R9 after");
      // R9: held return-from-interrupt releases silently
      s = idle(); s.rfi = 1;                                   cyc(s, 1, "R9 rfi hold");
      s = idle(); s.pf = 1;                                    cyc(s, 0, "R9 rfi release");
      s = idle(); s.vld = 0;                                   cyc(s, 0, "R9 rfi after");
      s = idle(); s.rfi = 1;                                   cyc(s, 0, "R9 rfi free");
      // R11: back-to-back strobes
      s = idle(); s.pf = 1;                                    cyc(s, 0, "R11 a");
      s = idle(); s.tw = 1; s.th = 1;                          cyc(s, 0, "R11 b");
      s = idle(); s.vld = 0;                                   cyc(s, 0, "R11 idle");
      s = idle(); s.vld = 0;                                   cyc(s, 0, "R11 idle");
      while (exp_q.size() > 0) @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      wrap_up();
   end
endmodule